// File: doc/BRIEF.md
# Refill-Requesting Streaming Output FIFO

This block buffers streaming test data between a wide bus-side write port and a narrow output port that feeds a device under test. Software writes 64-bit words. The consumer removes 16-bit words, one per cycle, by asserting a read enable. Each accepted wide word is split into four narrow entries. The least significant 16 bits leave first.

The block tracks its fill level in narrow entries and reports three conditions: empty, half-empty and no room for another wide word. While the level is at or below half of capacity, a level-sensitive interrupt asks software to fetch and write the next burst. A read attempted while the buffer is empty is not silently ignored. It sets a sticky underflow flag, which stays set until a dedicated clear pulse arrives.

Top module: `stream_refill_fifo`

## Requirements
- R1: After a synchronous active-high reset, the block holds no data. In that state `empty`, `half_empty` and `irq` are 1, `full` and `underflow` are 0, and `rd_data` is 0.
- R2: The four 16-bit lanes of each accepted wide word leave in this order: bits [15:0], [31:16], [47:32], then [63:48]. Wide words leave in the order they were written.
- R3: A write is accepted only when at least four of the 512 narrow entries are free, that is when the level is 508 or less. `full` is 1 exactly when the level exceeds 508. A write offered while `full` is 1 is dropped and leaves the stored data unchanged.
- R4: `empty` is 1 exactly when the level is 0.
- R5: `half_empty` is 1 exactly when the level is 256 or less.
- R6: `irq` is 1 in every cycle in which `half_empty` is 1, and 0 otherwise.
- R7: A read offered while `empty` is 1 sets `underflow` on the next clock edge, and `rd_data` keeps its previous value.
- R8: `underflow` stays set until `underflow_clr` is pulsed. If an underflowing read and a clear occur in the same cycle, the flag stays set.
- R9: When an accepted write and an accepted read occur in the same cycle, both take effect. The level then rises by 3.
- R10: `rd_data` changes only on the clock edge that follows an accepted read. One registered cycle after that read, it shows the oldest stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Offer one wide word |
| wr_data | input | 64 | Wide word from the bus side |
| rd_en | input | 1 | Consumer requests one narrow word |
| rd_data | output | 16 | Registered narrow word toward the device under test |
| empty | output | 1 | No entries stored |
| half_empty | output | 1 | Level at or below half capacity |
| full | output | 1 | Fewer than four entries free |
| irq | output | 1 | Refill request, a level signal |
| underflow | output | 1 | Sticky flag: a read was attempted while empty |
| underflow_clr | input | 1 | Clears the underflow flag |

## Verification
The main function is driven with three random traffic mixes. A write-heavy mix pushes the level into the full region, so accepted writes can be told apart from dropped ones. A read-heavy mix drains the buffer and repeatedly attempts reads while empty, which separates honoured reads from underflow. A balanced mix crosses the 256 half-way point many times and produces many same-cycle read and write pairs. Directed cases add the following:
- a complete fill with a distinctive dropped write, followed by a full drain that proves the dropped word never appears;
- a simultaneous read and write at level 0;
- a clear pulse that coincides with an underflow.

// File: rtl/stream_fifo_pkg.sv
package stream_fifo_pkg;

  // Level after one cycle, counted in narrow entries.
  function automatic int unsigned level_step(int unsigned lvl, bit wr_ok, bit rd_ok,
                                             int unsigned lanes);
    int unsigned nxt;
    nxt = lvl;
    if (wr_ok) nxt = nxt + lanes;
    if (rd_ok) nxt = nxt - 1;
    return nxt;
  endfunction

  // Room for one more wide word.
  function automatic bit has_room(int unsigned lvl, int unsigned depth, int unsigned lanes);
    return (lvl + lanes) <= depth;
  endfunction

  // Refill threshold: at or below half capacity.
  function automatic bit refill_due(int unsigned lvl, int unsigned depth);
    return lvl <= (depth / 2);
  endfunction

endpackage

// File: rtl/sfifo_level.sv
module sfifo_level
  import stream_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int LANES = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_accept,
  output logic             rd_accept,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             half_empty,
  output logic             full
);

  logic room;

  always_comb begin
    room       = has_room(32'(level), DEPTH, LANES);
    empty      = (level == '0);
    full       = !room;
    half_empty = refill_due(32'(level), DEPTH);
    wr_accept  = wr_en && room;
    rd_accept  = rd_en && !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= LVL_W'(level_step(32'(level), wr_accept, rd_accept, LANES));
  end

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 16,
  parameter int DEPTH = 512,
  localparam int LANES  = IN_W / OUT_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORDS  = DEPTH / LANES,
  localparam int WPTR_W = $clog2(WORDS),
  localparam int RPTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_accept,
  input  logic [IN_W-1:0]  wr_data,
  input  logic             rd_accept,
  output logic [OUT_W-1:0] rd_data
);

  logic [IN_W-1:0]   mem [WORDS];
  logic [WPTR_W-1:0] wptr;
  logic [RPTR_W-1:0] rptr;
  logic [WPTR_W-1:0] rword;
  logic [LANE_W-1:0] rlane;
  logic [IN_W-1:0]   cur_word;
  logic [OUT_W-1:0]  cur_lane;

  always_comb begin
    rword    = rptr[RPTR_W-1:LANE_W];
    rlane    = rptr[LANE_W-1:0];
    cur_word = mem[rword];
    cur_lane = cur_word[rlane*OUT_W +: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_accept) wptr <= wptr + 1'b1;
      if (rd_accept) begin
        rptr    <= rptr + 1'b1;
        rd_data <= cur_lane;
      end
    end
  end

endmodule

// File: rtl/sfifo_underflow.sv
module sfifo_underflow (
  input  logic clk,
  input  logic rst,
  input  logic bad_read,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (bad_read) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

endmodule

// File: rtl/stream_refill_fifo.sv
module stream_refill_fifo #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 16,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  wr_data,
  input  logic             rd_en,
  output logic [OUT_W-1:0] rd_data,
  output logic             empty,
  output logic             half_empty,
  output logic             full,
  output logic             irq,
  input  logic             underflow_clr,
  output logic             underflow
);

  localparam int LANES = IN_W / OUT_W;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             wr_accept;
  logic             rd_accept;
  logic             bad_read;
  logic [LVL_W-1:0] level;

  sfifo_level #(.DEPTH(DEPTH), .LANES(LANES)) u_level (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .wr_accept(wr_accept), .rd_accept(rd_accept), .level(level),
    .empty(empty), .half_empty(half_empty), .full(full)
  );

  sfifo_store #(.IN_W(IN_W), .OUT_W(OUT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_accept(wr_accept), .wr_data(wr_data),
    .rd_accept(rd_accept), .rd_data(rd_data)
  );

  assign bad_read = rd_en && empty;

  sfifo_underflow u_uflow (
    .clk(clk), .rst(rst), .bad_read(bad_read), .clr(underflow_clr), .flag(underflow)
  );

  assign irq = half_empty;

endmodule

// File: rtl/stream_refill_fifo_checker.sv
module stream_refill_fifo_checker #(
  parameter int OUT_W = 16,
  parameter int DEPTH = 512,
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_accept,
  input logic             rd_accept,
  input logic             rd_en,
  input logic             underflow_clr,
  input logic [LVL_W-1:0] level,
  input logic [OUT_W-1:0] rd_data,
  input logic             empty,
  input logic             full,
  input logic             irq,
  input logic             underflow
);

  p_full_drops_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_accept);

  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    32'(level) <= DEPTH);

  p_empty_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_accept);

  p_irq_refill_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(level) <= DEPTH / 2) |-> irq);

  p_uflow_set_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> underflow);

  p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (underflow && !underflow_clr) |=> underflow);

  p_both_step_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_accept && rd_accept) |=> (32'(level) == 32'($past(level)) + 3));

  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_accept |=> $stable(rd_data));

endmodule

bind stream_refill_fifo stream_refill_fifo_checker #(
  .OUT_W(OUT_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_accept(wr_accept), .rd_accept(rd_accept),
  .rd_en(rd_en), .underflow_clr(underflow_clr), .level(level),
  .rd_data(rd_data), .empty(empty), .full(full), .irq(irq), .underflow(underflow)
);

// File: tb/stream_refill_fifo_bench.sv
module stream_refill_fifo_bench;

  localparam int CAP = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        underflow_clr = 1'b0;
  logic [15:0] rd_data;
  logic        empty, half_empty, full, irq, underflow;

  int checks = 0;
  int fails  = 0;

  logic [15:0] q[$];
  logic [15:0] exp_data = '0;
  bit          exp_uf = 1'b0;

  always #4 clk = ~clk;

  stream_refill_fifo u_stream_refill_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .half_empty(half_empty), .full(full),
    .irq(irq), .underflow_clr(underflow_clr), .underflow(underflow)
  );

  function automatic bit m_full(int n);  return n > CAP - 4;  endfunction
  function automatic bit m_half(int n);  return n * 2 <= CAP; endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R10/R2 rd_data", 64'(rd_data), 64'(exp_data));
    check("R4 empty", 64'(empty), 64'(q.size() == 0));
    check("R5 half_empty", 64'(half_empty), 64'(m_half(q.size())));
    check("R6 irq", 64'(irq), 64'(m_half(q.size())));
    check("R3 full", 64'(full), 64'(m_full(q.size())));
    check("R7/R8 underflow", 64'(underflow), 64'(exp_uf));
  endtask

  // One cycle: drive at the falling edge, predict, sample 1 ns after the rising edge.
  task automatic step(bit wr, logic [63:0] d, bit rd, bit clr);
    int  n0;
    bit  wok, rok;
    @(negedge clk);
    wr_en = wr; wr_data = d; rd_en = rd; underflow_clr = clr;
    n0  = q.size();
    wok = wr && !m_full(n0);
    rok = rd && (n0 != 0);
    if (rok) exp_data = q.pop_front();
    if (wok) for (int k = 0; k < 4; k++) q.push_back(d[k*16 +: 16]);
    if (rd && n0 == 0) exp_uf = 1'b1;
    else if (clr)      exp_uf = 1'b0;
    @(posedge clk);
    #1;
    check_all();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #1_400_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check_all(); // R1 reset state
    check("R1 rd_data zero", 64'(rd_data), 64'h0);

    // R7: read while empty; the write in the same cycle is kept.
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 64'h4444_3333_2222_1111, 1'b1, 1'b0); // R9 at level 0: read refused
    check("R9 level after empty rw", 64'(q.size()), 64'd4);
    // R8: clear together with a bad read keeps the flag set.
    step(1'b0, '0, 1'b1, 1'b0); // take 1111
    check("R2 first lane", 64'(rd_data), 64'h1111);
    step(1'b1, 64'h8888_7777_6666_5555, 1'b1, 1'b0); // R9: +4 -1
    repeat (6) step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b1); // empty read + clr: stays set
    check("R8 set beats clear", 64'(underflow), 64'd1);
    step(1'b0, '0, 1'b0, 1'b1);
    check("R8 cleared", 64'(underflow), 64'd0);

    // R3: fill to the limit, offer a marker write, then drain.
    for (int i = 0; i < 128; i++) step(1'b1, {16'(i*4+3), 16'(i*4+2), 16'(i*4+1), 16'(i*4)}, 1'b0, 1'b0);
    check("R3 full at capacity", 64'(full), 64'd1);
    step(1'b1, 64'hDEAD_DEAD_DEAD_DEAD, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b1, 64'hBEEF_BEEF_BEEF_BEEF, 1'b0, 1'b0); // level 511: dropped
    for (int i = 0; i < 511; i++) begin
      step(1'b0, '0, 1'b1, 1'b0);
      check("R3 no dropped word", 64'(rd_data == 16'hDEAD || rd_data == 16'hBEEF), 64'd0);
    end

    // Random phases: write-heavy, read-heavy, balanced.
    for (int ph = 0; ph < 3; ph++) begin
      int wp, rp;
      wp = (ph == 0) ? 80 : (ph == 1) ? 15 : 30;
      rp = (ph == 0) ? 40 : (ph == 1) ? 90 : 85;
      for (int c = 0; c < 1500; c++)
        step(($urandom() % 100) < wp, rnd64(), ($urandom() % 100) < rp, ($urandom() % 16) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule